// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block carries data between two 18-bit ports, A and B, along two separate paths, A-to-B and B-to-A. Each path has a storage register, a latch-enable input, a capture-clock input and an output-enable input. The latch-enable and the capture clock together set the path's mode. In pass-through mode the input goes straight to the opposite port. In hold mode the stored word drives that port. In capture mode the stored word is loaded on a rising edge of the capture clock.

The ports carry no tri-state drivers. Each side has a data input, a data output and an output-enable flag, and the pad ring outside the block does the actual bus driving. The system clock samples the capture-clock inputs, so the block is fully synchronous and infers no latches. A rising edge is recognised when one sample is high and the sample before it was low.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Both paths are `DATA_W` bits wide, and `DATA_W` defaults to 18.
- R2: While a path's latch-enable is high and its output-enable is high, the opposite port's data output equals the path's data input in the same cycle, with no register in between.
- R3: While the latch-enable is low and the sampled capture clock has no low-to-high step, the stored word keeps its value. The opposite port then shows that stored word.
- R4: With the latch-enable low, a capture-clock sample of 1 that follows a sample of 0 loads the data input into the stored word at that system edge. The new word appears at the output from the next cycle on.
- R5: While the latch-enable is high, the stored word reloads from the input on every system edge. After the enable falls, the output therefore keeps showing the last word that passed through.
- R6: While a path's output-enable is low, the matching flag (`b_oe_o` for A-to-B, `a_oe_o` for B-to-A) is low and that port's data output is all zeros.
- R7: The two paths share no state. Activity on one path's latch-enable or capture clock never changes the other path's stored word.
- R8: While `rst_ni` is low, both stored words are zero, both output-enable flags are low and both data outputs are zero. The last capture-clock sample is preset to 1, so a capture clock held high across reset release causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Data in from port A |
| b_i | input | 18 | Data in from port B |
| ab_le_i | input | 1 | A-to-B latch-enable (1 = pass-through) |
| ab_clk_i | input | 1 | A-to-B capture clock, sampled |
| ab_oe_i | input | 1 | Output-enable for port B, active high |
| ba_le_i | input | 1 | B-to-A latch-enable (1 = pass-through) |
| ba_clk_i | input | 1 | B-to-A capture clock, sampled |
| ba_oe_i | input | 1 | Output-enable for port A, active high |
| a_o | output | 18 | Data out to port A |
| a_oe_o | output | 1 | Port A drive flag |
| b_o | output | 18 | Data out to port B |
| b_oe_o | output | 1 | Port B drive flag |

## Verification
The bench holds the A-to-B capture clock high across reset release. A design that did not preset the sample history would then capture a spurious word. The bench lowers the latch-enable with no clock edge and checks that the last word passed is kept. A design that updated storage only on clock edges would instead show stale data there. It then toggles one path's capture clock while the other path holds, which exposes any shared or cross-wired storage. Long random runs mix the three modes and the output-enables, so that a design that let the clock win over the latch-enable, or that left data on a disabled port, would mismatch the model.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned DIR_N = 2;
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic rise_o
);
  logic smp_q;

  // preset high: a level held across reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b1;
    else         smp_q <= smp_i;
  end

  assign rise_o = smp_i & ~smp_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              rise_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] q_o,
  output xcvr_mode_e        mode_o
);
  logic [DATA_W-1:0] q_r;

  always_comb begin
    if (le_i)        mode_o = MODE_PASS;
    else if (rise_i) mode_o = MODE_CAPTURE;
    else             mode_o = MODE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else if (mode_o != MODE_HOLD) q_r <= din_i;
  end

  assign q_o = q_r;

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i) |=> $stable(q_o));
  // R4
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise_i) |=> (q_o == $past(din_i)));
  // R5
  pass_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q_o == $past(din_i)));
endmodule

// File: rtl/xcvr_out_gate.sv
module xcvr_out_gate
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_i,
  input  logic              le_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] q_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o
);
  logic en;
  assign en     = oe_i & rst_ni;
  assign oe_o   = en;
  assign dout_o = !en ? '0 : (le_i ? din_i : q_i);

  // R6
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (dout_o == '0 && !oe_o));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ab_le_i,
  input  logic              ab_clk_i,
  input  logic              ab_oe_i,
  input  logic              ba_le_i,
  input  logic              ba_clk_i,
  input  logic              ba_oe_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o
);
  logic [DATA_W-1:0] din  [DIR_N];
  logic [DATA_W-1:0] dout [DIR_N];
  logic [DATA_W-1:0] q    [DIR_N];
  logic [DIR_N-1:0]  le, cap, oe, oe_flag, rise;
  xcvr_mode_e        mode [DIR_N];

  assign din[DIR_AB] = a_i;
  assign din[DIR_BA] = b_i;
  assign le  = {ba_le_i,  ab_le_i};
  assign cap = {ba_clk_i, ab_clk_i};
  assign oe  = {ba_oe_i,  ab_oe_i};

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    xcvr_edge_det u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (cap[d]),
      .rise_o(rise[d])
    );
    xcvr_store #(.DATA_W(DATA_W)) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .le_i  (le[d]),
      .rise_i(rise[d]),
      .din_i (din[d]),
      .q_o   (q[d]),
      .mode_o(mode[d])
    );
    xcvr_out_gate #(.DATA_W(DATA_W)) u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .oe_i  (oe[d]),
      .le_i  (le[d]),
      .din_i (din[d]),
      .q_i   (q[d]),
      .dout_o(dout[d]),
      .oe_o  (oe_flag[d])
    );
  end

  assign b_o    = dout[DIR_AB];
  assign b_oe_o = oe_flag[DIR_AB];
  assign a_o    = dout[DIR_BA];
  assign a_oe_o = oe_flag[DIR_BA];

  // R7
  ab_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[DIR_AB] == MODE_HOLD) |=> $stable(q[DIR_AB]));
  // R7
  ba_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[DIR_BA] == MODE_HOLD) |=> $stable(q[DIR_BA]));
endmodule

// File: tb/bus_xcvr_reg_bench.sv
`timescale 1ns/1ps
module bus_xcvr_reg_bench;
  localparam int W = 18;
  localparam int MASKV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_ck = 1, ab_oe = 0;
  logic ba_le = 0, ba_ck = 0, ba_oe = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  int st_ab = 0, st_ba = 0;
  bit pk_ab = 1, pk_ba = 1;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.DATA_W(W)) u_bus_xcvr_reg (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .b_i(b_in),
    .ab_le_i(ab_le), .ab_clk_i(ab_ck), .ab_oe_i(ab_oe),
    .ba_le_i(ba_le), .ba_clk_i(ba_ck), .ba_oe_i(ba_oe),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ab = 0; st_ba = 0; pk_ab = 1; pk_ba = 1;
    end else begin
      if (ab_le || (ab_ck && !pk_ab)) st_ab = int'(a_in);
      if (ba_le || (ba_ck && !pk_ba)) st_ba = int'(b_in);
      pk_ab = ab_ck; pk_ba = ba_ck;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(bit le, bit oe);
    if (!rst_n) return "R8";
    if (!oe)    return "R6";
    if (le)     return "R2";
    return "R3/R4/R5";
  endfunction

  task automatic compare_all();
    int eb, ea;
    eb = (rst_n && ab_oe) ? (ab_le ? int'(a_in) : st_ab) : 0;
    ea = (rst_n && ba_oe) ? (ba_le ? int'(b_in) : st_ba) : 0;
    chk(tag_of(ab_le, ab_oe), int'(b_out), eb);
    chk(tag_of(ba_le, ba_oe), int'(a_out), ea);
    chk(rst_n ? "R6" : "R8", int'(b_oe), int'(rst_n & ab_oe));
    chk(rst_n ? "R6" : "R8", int'(a_oe), int'(rst_n & ba_oe));
  endtask

  // one system cycle: drive after the falling edge, compare shortly after
  task automatic step();
    @(negedge clk);
    #0.5;
    compare_all();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state with enables requested
    a_in = 18'h15a5a; b_in = 18'h2c3c3; ab_oe = 1; ba_oe = 1;
    repeat (3) step();
    chk("R8", int'(b_out), 0);
    chk("R8", int'(b_oe), 0);
    // R8: capture clock high across release must not capture
    @(negedge clk); rst_n = 1; ab_le = 0; ab_ck = 1;
    step(); step();
    chk("R8", int'(b_out), 0);
    // R1: full-width pass-through
    @(negedge clk); ab_le = 1; a_in = W'(MASKV); #0.5;
    chk("R1", int'(b_out), MASKV);
    chk("R2", int'(b_out), MASKV);
    step();
    // R5: lower LE with no clock edge; last passed word kept
    @(negedge clk); a_in = 18'h00abc; #0.5;
    chk("R2", int'(b_out), 'habc);
    @(negedge clk); ab_le = 0; a_in = 18'h3ffff - 18'h1; #0.5;
    chk("R5", int'(b_out), 'habc);
    // R4: capture on sampled rising edge
    @(negedge clk); ab_ck = 0; #0.5; compare_all();
    @(negedge clk); a_in = 18'h12345; ab_ck = 1; #0.5;
    chk("R3", int'(b_out), 'habc);
    @(negedge clk); a_in = 18'h0; #0.5;
    chk("R4", int'(b_out), 'h12345);
    // R3: clock held low, data changes ignored
    @(negedge clk); ab_ck = 0; a_in = 18'h3f0f0;
    step(); step();
    chk("R3", int'(b_out), 'h12345);
    // R7: toggle B-to-A clock and LE; A-to-B stays
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ba_ck = ~ba_ck; ba_le = i[2]; b_in = W'(i * 77 + 5); #0.5;
      chk("R7", int'(b_out), 'h12345);
    end
    // R6: disable port B output
    @(negedge clk); ab_oe = 0; ab_le = 1; a_in = 18'h2aaaa; #0.5;
    chk("R6", int'(b_out), 0);
    chk("R6", int'(b_oe), 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      a_in = W'($urandom); b_in = W'($urandom);
      ab_le = ($urandom % 5) == 0; ba_le = ($urandom % 5) == 0;
      ab_ck = $urandom % 2; ba_ck = $urandom % 2;
      ab_oe = ($urandom % 6) != 0; ba_oe = ($urandom % 6) != 0;
      #0.5; compare_all();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule